// File: doc/BRIEF.md
# Effective Address Generator

This block works out the memory address of an operand for the register-indirect family of addressing modes, and at the same time the value the address register should hold afterwards. A decoder presents one request per cycle: the addressing mode, the operand size, the address register's number and contents, an index register, the program counter and the extension word from the instruction stream. One cycle later the block returns the 32-bit effective address and its low 24 bits for the external bus. It also returns the updated address register and a write enable that the register file uses to store that value.

Post-increment and pre-decrement step the register by the operand size. A byte step on the stack-pointer register is widened to two, so the stack stays word-aligned. Displacement and index forms add sign-extended offsets to an address register or to the program counter. The index can be used as a sign-extended low word or as a full long word. Absolute short addresses are sign-extended. Instruction decode and bus cycles are handled elsewhere.

Top module: `eag_top`

## Requirements
- R1: After reset `out_valid_o`, `areg_we_o`, `ea_o`, `bus_addr_o` and `areg_new_o` are all zero.
- R2: A request sampled with `req_i` high at a rising edge yields its results with `out_valid_o` high after that same edge. A cycle with `req_i` low yields `out_valid_o` low and `areg_we_o` low.
- R3: Mode 0 (plain indirect) gives `ea_o` equal to the address register, with `areg_new_o` equal to the register and `areg_we_o` low.
- R4: Mode 1 (post-increment) gives `ea_o` equal to the register value before the step, `areg_new_o` equal to that value plus the step, and `areg_we_o` high.
- R5: Mode 2 (pre-decrement) gives `areg_new_o` equal to the register minus the step, `ea_o` equal to that new value, and `areg_we_o` high.
- R6: The step is 1 for size code 0 (byte), 2 for size code 1 (word) and 4 for size codes 2 and 3 (long). When the register number is 7, a byte step becomes 2.
- R7: Mode 3 gives the address register plus `ext_i[15:0]` sign-extended.
- R8: Mode 4 gives the address register plus the index term plus `ext_i[7:0]` sign-extended. The index term is `xreg_i` when `idx_long_i` is 1, and `xreg_i[15:0]` sign-extended when it is 0.
- R9: Mode 5 gives `pc_i` plus `ext_i[15:0]` sign-extended. Mode 6 gives `pc_i` plus the index term (as in R8) plus `ext_i[7:0]` sign-extended.
- R10: Mode 7 gives `ext_i[15:0]` sign-extended to 32 bits. Mode 8 gives `ext_i` unchanged.
- R11: All sums wrap modulo 2^32. `bus_addr_o` carries `ea_o[23:0]`, and the upper byte of the address has no effect on it.
- R12: Mode codes 9 to 15 give `ea_o` zero, `areg_new_o` equal to the register and `areg_we_o` low.
- R13: In modes 3 to 8 `areg_new_o` equals the incoming address register and `areg_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe for this cycle |
| mode_i | input | 4 | Addressing mode code (0 to 8 used) |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| regnum_i | input | 3 | Number of the address register in use |
| areg_i | input | 32 | Address register contents |
| xreg_i | input | 32 | Index register contents |
| idx_long_i | input | 1 | 1 uses the whole index, 0 uses its sign-extended low word |
| pc_i | input | 32 | Program counter base |
| ext_i | input | 32 | Extension word: displacement or absolute address |
| out_valid_o | output | 1 | Results below belong to the previous cycle's request |
| ea_o | output | 32 | Effective address |
| bus_addr_o | output | 24 | Low 24 bits of the effective address |
| areg_new_o | output | 32 | Address register value after the access |
| areg_we_o | output | 1 | Write enable for `areg_new_o` |

## Verification
The bench goes after the step size on each operand size. It covers the byte step on register 7, which a design without the alignment rule would advance by one. It checks ordering in the stepping modes: swapping add-then-use with use-then-subtract would put the wrong address on the bus. It drives negative 8-bit and 16-bit offsets and word-sized index values with bit 15 set, where missing sign extension produces an address 64 KiB or 256 bytes off. Sums that carry across bit 23 and unused mode codes catch a design that leaks the high byte onto the bus or writes the register when it must not.

// File: rtl/eag_pkg.sv
// Shared definitions for the effective address generator.
// Assumes: mode codes are fixed and decoded by the instruction decoder.
package eag_pkg;
    typedef enum logic [3:0] {
        AM_IND       = 4'd0,
        AM_POSTINC   = 4'd1,
        AM_PREDEC    = 4'd2,
        AM_DISP      = 4'd3,
        AM_INDEX     = 4'd4,
        AM_PC_DISP   = 4'd5,
        AM_PC_INDEX  = 4'd6,
        AM_ABS_SHORT = 4'd7,
        AM_ABS_LONG  = 4'd8
    } am_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/eag_step.sv
// Step amount for the stepping modes, taken from the operand size.
// Assumes: size code 0 byte, 1 word, 2/3 long. With SP_ALIGN set, a byte
// step on register SP_REG is widened to keep that register word-aligned.
module eag_step #(
    parameter int AW       = 32,
    parameter int RNW      = 3,
    parameter int SP_REG   = 7,
    parameter bit SP_ALIGN = 1'b1
) (
    input  logic [1:0]     size_i,
    input  logic [RNW-1:0] regnum_i,
    output logic [AW-1:0]  step_o
);
    import eag_pkg::*;

    logic [AW-1:0] raw_step;

    // purpose: plain size-to-byte-count mapping
    always_comb begin
        case (size_i)
            SZ_BYTE: raw_step = AW'(1);
            SZ_WORD: raw_step = AW'(2);
            default: raw_step = AW'(4);
        endcase
    end

    generate
        if (SP_ALIGN) begin : g_align
            logic on_sp;
            assign on_sp = (regnum_i == RNW'(SP_REG));
            // purpose: widen byte steps on the stack register
            always_comb begin
                step_o = raw_step;
                if (on_sp && size_i == SZ_BYTE) step_o = AW'(2);
            end
        end else begin : g_plain
            logic unused_rn;
            assign unused_rn = ^regnum_i;
            assign step_o    = raw_step;
        end
    endgenerate
endmodule

// File: rtl/eag_index.sv
// Index term for the indexed modes: index register (whole or sign-extended
// low word) plus a sign-extended 8-bit offset.
// Assumes: AW is at least 16.
module eag_index #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] xreg_i,
    input  logic          idx_long_i,
    input  logic [7:0]    d8_i,
    output logic [AW-1:0] term_o
);
    localparam int HW = 16;
    localparam int BW = 8;

    logic [AW-1:0] x_sel;
    logic [AW-1:0] d8_ext;

    // purpose: pick whole index or sign-extended low word
    always_comb begin
        if (idx_long_i) x_sel = xreg_i;
        else            x_sel = {{(AW-HW){xreg_i[HW-1]}}, xreg_i[HW-1:0]};
    end

    // purpose: sign-extend the short offset
    always_comb d8_ext = {{(AW-BW){d8_i[BW-1]}}, d8_i};

    // purpose: sum of the two index contributions
    always_comb term_o = x_sel + d8_ext;
endmodule

// File: rtl/eag_calc.sv
// Combinational address and write-back computation for one request.
// Assumes: step and index term are supplied by their own units; unused
// mode codes yield a zero address and no write-back.
module eag_calc #(
    parameter int AW = 32
) (
    input  logic [3:0]    mode_i,
    input  logic [AW-1:0] areg_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] ext_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] idx_term_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] new_o,
    output logic          upd_o
);
    import eag_pkg::*;

    localparam int HW = 16;

    logic [AW-1:0] d16_ext;
    logic [AW-1:0] dec_val;
    logic [AW-1:0] inc_val;

    // purpose: shared sign-extended 16-bit field
    always_comb d16_ext = {{(AW-HW){ext_i[HW-1]}}, ext_i[HW-1:0]};

    // purpose: both candidate stepped register values
    always_comb begin
        inc_val = areg_i + step_i;
        dec_val = areg_i - step_i;
    end

    // purpose: select address, new register value and enable by mode
    always_comb begin
        ea_o  = '0;
        new_o = areg_i;
        upd_o = 1'b0;
        case (mode_i)
            AM_IND:       ea_o = areg_i;
            AM_POSTINC: begin
                ea_o  = areg_i;
                new_o = inc_val;
                upd_o = 1'b1;
            end
            AM_PREDEC: begin
                ea_o  = dec_val;
                new_o = dec_val;
                upd_o = 1'b1;
            end
            AM_DISP:      ea_o = areg_i + d16_ext;
            AM_INDEX:     ea_o = areg_i + idx_term_i;
            AM_PC_DISP:   ea_o = pc_i + d16_ext;
            AM_PC_INDEX:  ea_o = pc_i + idx_term_i;
            AM_ABS_SHORT: ea_o = d16_ext;
            AM_ABS_LONG:  ea_o = ext_i;
            default: begin
                ea_o  = '0;
                new_o = areg_i;
                upd_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eag_top.sv
// Effective address generator top: one request per cycle, results one
// cycle later. Registers the address, the stepped register and its enable.
// Assumes: synchronous active-low reset; the caller holds no handshake.
module eag_top #(
    parameter int AW     = 32,
    parameter int BUS_AW = 24,
    parameter int RNW    = 3,
    parameter int SP_REG = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [3:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [RNW-1:0]    regnum_i,
    input  logic [AW-1:0]     areg_i,
    input  logic [AW-1:0]     xreg_i,
    input  logic              idx_long_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [AW-1:0]     ext_i,
    output logic              out_valid_o,
    output logic [AW-1:0]     ea_o,
    output logic [BUS_AW-1:0] bus_addr_o,
    output logic [AW-1:0]     areg_new_o,
    output logic              areg_we_o
);
    import eag_pkg::*;

    logic [AW-1:0] step_w;
    logic [AW-1:0] idx_w;
    logic [AW-1:0] ea_w;
    logic [AW-1:0] new_w;
    logic          upd_w;

    eag_step #(.AW(AW), .RNW(RNW), .SP_REG(SP_REG), .SP_ALIGN(1'b1)) u_step (
        .size_i   (size_i),
        .regnum_i (regnum_i),
        .step_o   (step_w)
    );

    eag_index #(.AW(AW)) u_index (
        .xreg_i     (xreg_i),
        .idx_long_i (idx_long_i),
        .d8_i       (ext_i[7:0]),
        .term_o     (idx_w)
    );

    eag_calc #(.AW(AW)) u_calc (
        .mode_i     (mode_i),
        .areg_i     (areg_i),
        .pc_i       (pc_i),
        .ext_i      (ext_i),
        .step_i     (step_w),
        .idx_term_i (idx_w),
        .ea_o       (ea_w),
        .new_o      (new_w),
        .upd_o      (upd_w)
    );

    // purpose: capture results of a request; clear enable when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            ea_o        <= '0;
            areg_new_o  <= '0;
            areg_we_o   <= 1'b0;
        end else begin
            out_valid_o <= req_i;
            areg_we_o   <= req_i & upd_w;
            if (req_i) begin
                ea_o       <= ea_w;
                areg_new_o <= new_w;
            end
        end
    end

    // purpose: only the low address bits reach the bus
    assign bus_addr_o = ea_o[BUS_AW-1:0];

    logic [AW-1:0] stepped_by;
    assign stepped_by = areg_new_o - ea_o;

    AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        areg_we_o |-> out_valid_o); // R2
    AST_POSTINC_OLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i) == 4'(AM_POSTINC)) |-> (ea_o == $past(areg_i) && areg_we_o)); // R4
    AST_PREDEC_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i) == 4'(AM_PREDEC)) |-> (ea_o == areg_new_o && areg_we_o)); // R5
    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i) == 4'(AM_POSTINC)) |->
        (stepped_by == AW'(1) || stepped_by == AW'(2) || stepped_by == AW'(4))); // R6
    AST_SP_ALIGNED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i) == 4'(AM_POSTINC) && $past(regnum_i) == RNW'(SP_REG)) |->
        (stepped_by != AW'(1))); // R6
    AST_ABS_SHORT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i) == 4'(AM_ABS_SHORT)) |->
        (ea_o[AW-1:16] == {(AW-16){ea_o[15]}})); // R10
    AST_UNUSED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i) > 4'(AM_ABS_LONG)) |-> (!areg_we_o && ea_o == '0)); // R12
    AST_NONSTEP_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_i) >= 4'(AM_DISP) && $past(mode_i) <= 4'(AM_ABS_LONG)) |->
        (!areg_we_o && areg_new_o == $past(areg_i))); // R13
endmodule

// File: tb/eag_top_test.sv
module eag_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic [2:0]  regnum_i = '0;
    logic [31:0] areg_i = '0, xreg_i = '0, pc_i = '0, ext_i = '0;
    logic        idx_long_i = 1'b0;
    logic        out_valid_o, areg_we_o;
    logic [31:0] ea_o, areg_new_o;
    logic [23:0] bus_addr_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    eag_top uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .size_i(size_i), .regnum_i(regnum_i), .areg_i(areg_i),
        .xreg_i(xreg_i), .idx_long_i(idx_long_i), .pc_i(pc_i),
        .ext_i(ext_i), .out_valid_o(out_valid_o), .ea_o(ea_o),
        .bus_addr_o(bus_addr_o), .areg_new_o(areg_new_o),
        .areg_we_o(areg_we_o)
    );

    function automatic logic [31:0] sx16(input logic [31:0] v);
        return {{16{v[15]}}, v[15:0]};
    endfunction
    function automatic logic [31:0] sx8(input logic [31:0] v);
        return {{24{v[7]}}, v[7:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one request at a falling edge, leave outputs settled for checking
    task automatic issue(input logic [3:0] m, input logic [1:0] sz, input logic [2:0] rn,
                         input logic [31:0] a, input logic [31:0] x, input logic il,
                         input logic [31:0] p, input logic [31:0] e);
        @(negedge clk);
        req_i = 1'b1; mode_i = m; size_i = sz; regnum_i = rn;
        areg_i = a; xreg_i = x; idx_long_i = il; pc_i = p; ext_i = e;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic expect_all(input string tag, input logic [31:0] ea, input logic [31:0] nw, input logic we);
        check({tag, " valid"}, 32'(out_valid_o), 32'd1);
        check({tag, " ea"}, ea_o, ea);
        check({tag, " bus"}, 32'(bus_addr_o), {8'h0, ea[23:0]});
        check({tag, " new"}, areg_new_o, nw);
        check({tag, " we"}, 32'(areg_we_o), 32'(we));
    endtask

    task automatic t_reset;
        check("R1 valid", 32'(out_valid_o), 0);
        check("R1 we", 32'(areg_we_o), 0);
        check("R1 ea", ea_o, 0);
        check("R1 bus", 32'(bus_addr_o), 0);
        check("R1 new", areg_new_o, 0);
    endtask

    task automatic t_indirect;
        issue(4'd0, 2'd2, 3'd2, 32'h0001_2344, 0, 0, 0, 0);
        expect_all("R3 indirect", 32'h0001_2344, 32'h0001_2344, 0);
    endtask

    task automatic t_postinc;
        issue(4'd1, 2'd0, 3'd1, 32'h100, 0, 0, 0, 0);
        expect_all("R4 R6 byte", 32'h100, 32'h101, 1);
        issue(4'd1, 2'd1, 3'd1, 32'h100, 0, 0, 0, 0);
        expect_all("R4 R6 word", 32'h100, 32'h102, 1);
        issue(4'd1, 2'd2, 3'd1, 32'h100, 0, 0, 0, 0);
        expect_all("R4 R6 long", 32'h100, 32'h104, 1);
        issue(4'd1, 2'd3, 3'd1, 32'h100, 0, 0, 0, 0);
        expect_all("R6 size3", 32'h100, 32'h104, 1);
        issue(4'd1, 2'd0, 3'd7, 32'h200, 0, 0, 0, 0);
        expect_all("R6 sp byte inc", 32'h200, 32'h202, 1);
        issue(4'd1, 2'd2, 3'd7, 32'hFFFF_FFFE, 0, 0, 0, 0);
        expect_all("R11 inc wrap", 32'hFFFF_FFFE, 32'h0000_0002, 1);
    endtask

    task automatic t_predec;
        issue(4'd2, 2'd0, 3'd3, 32'h100, 0, 0, 0, 0);
        expect_all("R5 R6 byte", 32'hFF, 32'hFF, 1);
        issue(4'd2, 2'd2, 3'd3, 32'h100, 0, 0, 0, 0);
        expect_all("R5 R6 long", 32'hFC, 32'hFC, 1);
        issue(4'd2, 2'd0, 3'd7, 32'h400, 0, 0, 0, 0);
        expect_all("R6 sp byte dec", 32'h3FE, 32'h3FE, 1);
    endtask

    task automatic t_disp;
        logic [31:0] a = 32'h0000_8000;
        issue(4'd3, 2'd1, 3'd0, a, 0, 0, 0, 32'h0000_0010);
        expect_all("R7 R13 pos", a + 32'h10, a, 0);
        issue(4'd3, 2'd1, 3'd0, a, 0, 0, 0, 32'h1234_FFF0);
        expect_all("R7 neg", a + sx16(32'hFFF0), a, 0);
    endtask

    task automatic t_index;
        logic [31:0] a = 32'h0010_0000;
        issue(4'd4, 2'd1, 3'd4, a, 32'h0003_8000, 0, 0, 32'h0000_00FC);
        expect_all("R8 word idx", a + sx16(32'h8000) + sx8(32'hFC), a, 0);
        issue(4'd4, 2'd1, 3'd4, a, 32'h0003_8000, 1, 0, 32'h0000_0005);
        expect_all("R8 long idx", a + 32'h0003_8000 + 32'h5, a, 0);
    endtask

    task automatic t_pc;
        logic [31:0] p = 32'h0000_4000;
        issue(4'd5, 2'd1, 3'd5, 32'hDEAD_BEEF, 0, 0, p, 32'h0000_FF00);
        expect_all("R9 pc disp", p + sx16(32'hFF00), 32'hDEAD_BEEF, 0);
        issue(4'd6, 2'd1, 3'd5, 32'h0, 32'h0000_0100, 0, p, 32'h0000_0080);
        expect_all("R9 pc index", p + 32'h100 + sx8(32'h80), 32'h0, 0);
    endtask

    task automatic t_abs;
        issue(4'd7, 2'd1, 3'd0, 32'h55, 0, 0, 0, 32'h0000_9ABC);
        expect_all("R10 short neg", 32'hFFFF_9ABC, 32'h55, 0);
        issue(4'd7, 2'd1, 3'd0, 32'h55, 0, 0, 0, 32'hFFFF_1234);
        expect_all("R10 short pos", 32'h0000_1234, 32'h55, 0);
        issue(4'd8, 2'd1, 3'd0, 32'h55, 0, 0, 0, 32'hAB12_3456);
        expect_all("R10 R11 long", 32'hAB12_3456, 32'h55, 0);
    endtask

    task automatic t_bus;
        issue(4'd3, 2'd1, 3'd0, 32'h7FFF_FFF0, 0, 0, 0, 32'h0000_0020);
        expect_all("R11 carry high", 32'h8000_0010, 32'h7FFF_FFF0, 0);
    endtask

    task automatic t_unused;
        for (int m = 9; m < 16; m++) begin
            issue(4'(m), 2'd2, 3'd1, 32'h0000_3000, 32'h1, 1, 32'h2, 32'h3);
            expect_all("R12 unused", 32'h0, 32'h0000_3000, 0);
        end
    endtask

    task automatic t_idle;
        issue(4'd1, 2'd2, 3'd1, 32'h500, 0, 0, 0, 0);
        expect_all("R2 request", 32'h500, 32'h504, 1);
        @(negedge clk);
        check("R2 idle valid", 32'(out_valid_o), 0);
        check("R2 idle we", 32'(areg_we_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 no req", 32'(out_valid_o), 0);
        t_indirect();
        t_postinc();
        t_predec();
        t_disp();
        t_index();
        t_pc();
        t_abs();
        t_bus();
        t_unused();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule